// File: doc/BRIEF.md
# Carry-Flag Bit Test Unit

This block carries out the single-bit carry operations of a small 8-bit controller core. Given two opcode bytes and a start strobe, it picks one bit and folds it into the carry flag in one of three ways. The bit can come from a general register, or from a byte fetched through a 16-bit pointer. In the pointer form the bit number is held in a general register. The unit keeps the carry flag (CF) and the jump flag (JF) itself and signals completion with a one-cycle done pulse.

The core's sequencer drives the two opcode bytes and pulses start. The unit has read access to the eight general registers, which arrive as one flattened vector, and to the two pointers. It reads memory through a synchronous port: a read requested in one cycle returns its data in the next. The register forms take two clock edges from the start edge, and the memory form takes four. While an operation is in flight, further start pulses are dropped.

Top module: `cfbit_unit`

## Requirements
- R1: A register form is recognised when the first opcode byte matches 8'b1110_1ggg, where ggg selects a register (register n sits at bits [8n+7:8n] of `regs_i`). The second byte 8'b1101_1bbb means load and 8'b1101_0bbb means exclusive-or, with bbb as the bit number (bit 0 = LSB).
- R2: The load register form sets CF to the selected bit and JF to its inverse.
- R3: The exclusive-or form sets CF to the old CF XOR the selected bit, and JF to the new CF.
- R4: For a register form, `done_o` is high in the cycle after the second rising edge following the start edge (start accepted at edge 1, result at edge 2). It is high for exactly one cycle.
- R5: With the first byte 8'b1110_1ggg, the second byte 8'h9E reads through `ptr_de_i` and 8'h9F reads through `ptr_hl_i`. The bit number is bits [2:0] of register ggg. CF takes the addressed bit of the fetched byte and JF takes its inverse.
- R6: In the memory form, `mem_re_o` is high for exactly one cycle, in the cycle right after the start edge, with `mem_addr_o` holding the selected pointer. Read data is taken one edge later, and `done_o` rises after the fourth edge.
- R7: Any other opcode pair gives `done_o` together with `illegal_o` two edges after start, and leaves CF and JF unchanged.
- R8: A start pulse that arrives while an operation is in progress is ignored, and the running operation completes with its own result.
- R9: After reset, CF, JF, `done_o`, `illegal_o` and `mem_re_o` are all 0.
- R10: CF and JF change only on the edge that raises `done_o` for a legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte |
| regs_i | input | 64 | Eight 8-bit registers, register n at [8n+7:8n] |
| ptr_de_i | input | 16 | First pointer |
| ptr_hl_i | input | 16 | Second pointer |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| cf_o | output | 1 | Carry flag |
| jf_o | output | 1 | Jump flag |
| done_o | output | 1 | Operation complete pulse |
| illegal_o | output | 1 | Unrecognised opcode, with done |

## Verification
The hardest case to reach is a start pulse that lands while a memory-form operation is waiting on its read data. A dropped start of this kind leaves no trace on any output. The stimulus therefore launches a pointer read and holds start high, with a different register opcode, through the three busy cycles that follow. The reference model then requires that the request, the latency and the final flags all belong to the first operation. Exclusive-or runs are chained after loads so that both old-CF values are exercised.

// File: rtl/cfbit_pkg.sv
package cfbit_pkg;
   typedef enum logic [1:0] {K_LDREG, K_XORREG, K_LDMEM, K_BAD} cf_kind_e;
   typedef enum logic [2:0] {S_IDLE, S_REG, S_MADDR, S_MWAIT, S_MEVAL} cf_state_e;

   localparam logic [4:0] OP0_PREFIX = 5'b11101;
   localparam logic [4:0] OP1_LOAD   = 5'b11011;
   localparam logic [4:0] OP1_XOR    = 5'b11010;
   localparam logic [6:0] OP1_MEM    = 7'b1001111;
endpackage

// File: rtl/cfbit_decode.sv
module cfbit_decode
   import cfbit_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic [OPW-1:0] op0_i,
   input  logic [OPW-1:0] op1_i,
   output cf_kind_e       kind_o,
   output logic [2:0]     gsel_o,
   output logic [2:0]     bsel_o
);
   localparam int PW = OPW - 3;

   generate
      if (OPW != 8) begin : g_bad_opw
         $error("cfbit_decode: opcode width must be 8");
      end
   endgenerate

   assign gsel_o = op0_i[2:0];
   assign bsel_o = op1_i[2:0];

   always_comb begin
      kind_o = K_BAD;
      if (op0_i[OPW-1:3] == OP0_PREFIX[PW-1:0]) begin
         if (op1_i[OPW-1:3] == OP1_LOAD[PW-1:0])
            kind_o = K_LDREG;
         else if (op1_i[OPW-1:3] == OP1_XOR[PW-1:0])
            kind_o = K_XORREG;
         else if (op1_i[OPW-1:1] == OP1_MEM)
            kind_o = K_LDMEM;
      end
   end
endmodule

// File: rtl/cfbit_regsel.sv
module cfbit_regsel #(
   parameter int NREG = 8,
   parameter int DW   = 8,
   localparam int SELW = $clog2(NREG)
) (
   input  logic [NREG*DW-1:0] regs_i,
   input  logic [SELW-1:0]    sel_i,
   output logic [DW-1:0]      data_o
);
   logic [DW-1:0] bank [NREG];

   generate
      for (genvar n = 0; n < NREG; n++) begin : g_unpack
         assign bank[n] = regs_i[n*DW +: DW];
      end
   endgenerate

   assign data_o = bank[sel_i];
endmodule

// File: rtl/cfbit_seq.sv
module cfbit_seq
   import cfbit_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  cf_kind_e kind_i,
   output logic     accept_o,
   output logic     busy_o,
   output logic     mem_re_o,
   output logic     capture_o,
   output logic     finish_o
);
   cf_state_e st_q, st_d;

   assign busy_o    = (st_q != S_IDLE);
   assign accept_o  = start_i && !busy_o;
   assign mem_re_o  = (st_q == S_MADDR);
   assign capture_o = (st_q == S_MWAIT);
   assign finish_o  = (st_q == S_REG) || (st_q == S_MEVAL);

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_IDLE:  if (start_i) st_d = (kind_i == K_LDMEM) ? S_MADDR : S_REG;
         S_REG:   st_d = S_IDLE;
         S_MADDR: st_d = S_MWAIT;
         S_MWAIT: st_d = S_MEVAL;
         S_MEVAL: st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   // R6: one read request per memory operation, data taken on the next edge
   a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> (!mem_re_o && capture_o));
   a_r6_eval_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |=> finish_o);
endmodule

// File: rtl/cfbit_unit.sv
module cfbit_unit
   import cfbit_pkg::*;
#(
   parameter int DW   = 8,
   parameter int AW   = 16,
   parameter int NREG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [7:0]        op0_i,
   input  logic [7:0]        op1_i,
   input  logic [NREG*DW-1:0] regs_i,
   input  logic [AW-1:0]     ptr_de_i,
   input  logic [AW-1:0]     ptr_hl_i,
   output logic              mem_re_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic [DW-1:0]     mem_rdata_i,
   output logic              cf_o,
   output logic              jf_o,
   output logic              done_o,
   output logic              illegal_o
);
   localparam int BW   = $clog2(DW);
   localparam int SELW = $clog2(NREG);

   generate
      if (DW != 8 || NREG != 8) begin : g_bad_cfg
         $error("cfbit_unit: 3-bit opcode fields need DW=8 and NREG=8");
      end
      if (AW < 1) begin : g_bad_aw
         $error("cfbit_unit: AW must be positive");
      end
   endgenerate

   cf_kind_e        kind_d, kind_q;
   logic [2:0]      gsel_d, bsel_d;
   logic [DW-1:0]   gdata, opnd_q;
   logic [BW-1:0]   bidx_q;
   logic [AW-1:0]   addr_q;
   logic            accept, busy, capture, finish, sel_bit;
   logic            cf_q, jf_q, done_q, ill_q;

   cfbit_decode #(.OPW(8)) u_dec (
      .op0_i(op0_i), .op1_i(op1_i),
      .kind_o(kind_d), .gsel_o(gsel_d), .bsel_o(bsel_d)
   );

   cfbit_regsel #(.NREG(NREG), .DW(DW)) u_rsel (
      .regs_i(regs_i), .sel_i(gsel_d[SELW-1:0]), .data_o(gdata)
   );

   cfbit_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_d),
      .accept_o(accept), .busy_o(busy), .mem_re_o(mem_re_o),
      .capture_o(capture), .finish_o(finish)
   );

   // operand capture: register byte at start, memory byte on capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_BAD;
         bidx_q <= '0;
         opnd_q <= '0;
         addr_q <= '0;
      end else if (accept) begin
         kind_q <= kind_d;
         bidx_q <= (kind_d == K_LDMEM) ? gdata[BW-1:0] : bsel_d[BW-1:0];
         opnd_q <= gdata;
         addr_q <= op1_i[0] ? ptr_hl_i : ptr_de_i;
      end else if (capture) begin
         opnd_q <= mem_rdata_i;
      end
   end

   assign sel_bit = opnd_q[bidx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cf_q   <= 1'b0;
         jf_q   <= 1'b0;
         done_q <= 1'b0;
         ill_q  <= 1'b0;
      end else begin
         done_q <= finish;
         ill_q  <= finish && (kind_q == K_BAD);
         if (finish) begin
            case (kind_q)
               K_LDREG, K_LDMEM: begin
                  cf_q <= sel_bit;
                  jf_q <= ~sel_bit;
               end
               K_XORREG: begin
                  cf_q <= cf_q ^ sel_bit;
                  jf_q <= cf_q ^ sel_bit;
               end
               default: ;
            endcase
         end
      end
   end

   assign mem_addr_o = addr_q;
   assign cf_o       = cf_q;
   assign jf_o       = jf_q;
   assign done_o     = done_q;
   assign illegal_o  = ill_q;

   // R4: completion is a single-cycle pulse
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: illegal is only reported together with done
   a_r7_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> done_o);
   // R10: flags hold unless a legal operation just completed
   a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o || illegal_o) |-> $stable({cf_o, jf_o}));
   // R2 / R5: load forms leave JF as the inverse of CF
   a_r2_load_jf_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (kind_q == K_LDREG || kind_q == K_LDMEM)) |-> (jf_o == !cf_o));
   // R3: exclusive-or leaves JF equal to CF
   a_r3_xor_jf_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && kind_q == K_XORREG) |-> (jf_o == cf_o));
   // R8: a start while busy does not disturb the captured operation
   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> ($stable(kind_q) && $stable(bidx_q) && $stable(addr_q)));
endmodule

// File: tb/cfbit_unit_tb_top.sv
module cfbit_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  op0_i = 8'h00, op1_i = 8'h00;
   logic [63:0] regs_i = '0;
   logic [15:0] ptr_de_i = 16'h0000, ptr_hl_i = 16'h0000;
   logic        mem_re_o;
   logic [15:0] mem_addr_o;
   logic [7:0]  mem_rdata_i = 8'h00;
   logic        cf_o, jf_o, done_o, illegal_o;

   int errors = 0, checks = 0;
   bit finished = 0;
   string cur_tag = "R9";

   always #10 clk = ~clk;   // 50 MHz

   cfbit_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op0_i(op0_i), .op1_i(op1_i),
      .regs_i(regs_i), .ptr_de_i(ptr_de_i), .ptr_hl_i(ptr_hl_i),
      .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
      .cf_o(cf_o), .jf_o(jf_o), .done_o(done_o), .illegal_o(illegal_o)
   );

   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] reg_f(input int g);
      return regs_i[g*8 +: 8];
   endfunction

   // synchronous memory: data appears the cycle after a request
   always @(posedge clk) mem_rdata_i <= mem_re_o ? mem_f(mem_addr_o) : 8'h00;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_busy, m_done, m_ill, m_re, m_cf, m_jf, p_cf, p_jf, p_ill;
   int m_cnt;
   logic [15:0] m_addr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_ill = 0; m_re = 0; m_cf = 0; m_jf = 0; m_cnt = 0;
      end else begin
         m_done = 0; m_ill = 0; m_re = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_ill = p_ill;
               if (!p_ill) begin m_cf = p_cf; m_jf = p_jf; end
            end
         end else if (start_i) begin
            int g, lat;
            bit b;
            g = int'(op0_i[2:0]);
            lat = 2; p_ill = 0;
            if (op0_i[7:3] != 5'b11101) p_ill = 1;
            else if (op1_i[7:3] == 5'b11011) begin
               b = reg_f(g)[op1_i[2:0]]; p_cf = b; p_jf = !b;
            end else if (op1_i[7:3] == 5'b11010) begin
               b = reg_f(g)[op1_i[2:0]]; p_cf = m_cf ^ b; p_jf = p_cf;
            end else if (op1_i == 8'h9E || op1_i == 8'h9F) begin
               m_addr = (op1_i == 8'h9F) ? ptr_hl_i : ptr_de_i;
               b = mem_f(m_addr)[reg_f(g)[2:0]];
               p_cf = b; p_jf = !b; lat = 4; m_re = 1;
            end else p_ill = 1;
            m_cnt = lat - 1; m_busy = 1;
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(cur_tag, "done", done_o, m_done);
         check(m_ill ? "R7" : cur_tag, "illegal", illegal_o, m_ill);
         check(cur_tag, "cf", cf_o, m_cf);
         check(cur_tag, "jf", jf_o, m_jf);
         check("R6", "mem_re", mem_re_o, m_re);
         if (m_re) check("R6", "mem_addr", mem_addr_o, m_addr);
      end
   end

   task automatic run_op(input logic [7:0] a, input logic [7:0] b, input string tag,
                         input int exp_lat, input int busy_starts);
      int n;
      cur_tag = tag;
      @(negedge clk); start_i = 1; op0_i = a; op1_i = b;
      @(negedge clk);
      n = 1;
      for (int k = 0; k < busy_starts; k++) begin
         op0_i = 8'hEA; op1_i = 8'hDF;  // a different legal op, must be ignored (R8)
         if (done_o) break;
         @(negedge clk); n++;
      end
      start_i = 0;
      while (!done_o && n < 10) begin @(negedge clk); n++; end
      check(exp_lat == 4 ? "R6" : (exp_lat == 2 && tag == "R7" ? "R7" : "R4"),
            "latency", n, exp_lat);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic sv_cf, sv_jf;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R9", "cf", cf_o, 0);   check("R9", "jf", jf_o, 0);
      check("R9", "done", done_o, 0); check("R9", "illegal", illegal_o, 0);
      check("R9", "mem_re", mem_re_o, 0);

      for (int g = 0; g < 8; g++) regs_i[g*8 +: 8] = 8'(8'h3C ^ (g * 8'h29));
      ptr_de_i = 16'h1234; ptr_hl_i = 16'hBEEF;

      // R1 / R2: load from register bits
      for (int g = 0; g < 8; g++)
         for (int b = 0; b < 8; b += 3)
            run_op({5'b11101, 3'(g)}, {5'b11011, 3'(b)}, "R2", 2, 0);

      // R3: exclusive-or chained so both old-CF values occur
      for (int i = 0; i < 16; i++)
         run_op({5'b11101, 3'(i % 8)}, {5'b11010, 3'((i * 5) % 8)}, "R3", 2, 0);

      // R5 / R6: memory forms through both pointers and several bit numbers
      for (int i = 0; i < 8; i++) begin
         regs_i[i*8 +: 8] = 8'(i * 8'h11);
         ptr_de_i = 16'(16'h0100 * i + 16'h0033);
         ptr_hl_i = 16'(16'hF00F - 16'h0111 * i);
         run_op({5'b11101, 3'(i)}, 8'h9E, "R5", 4, 0);
         run_op({5'b11101, 3'(i)}, 8'h9F, "R5", 4, 0);
      end

      // R7: unknown second byte, wrong prefix; flags must hold
      sv_cf = cf_o; sv_jf = jf_o;
      run_op(8'hE9, 8'h9C, "R7", 2, 0);
      run_op(8'hF1, 8'hDB, "R7", 2, 0);
      run_op(8'hEB, 8'h00, "R7", 2, 0);
      @(negedge clk);
      check("R7", "cf held", cf_o, sv_cf);
      check("R7", "jf held", jf_o, sv_jf);

      // R8: start kept high with another op while a memory read is pending
      run_op(8'hEB, 8'h9F, "R8", 4, 3);
      run_op(8'hEC, 8'h9E, "R8", 4, 2);
      run_op(8'hE1, 8'hD8, "R8", 2, 1);

      // back-to-back start in the done cycle
      cur_tag = "R4";
      @(negedge clk); start_i = 1; op0_i = 8'hE2; op1_i = 8'hD9;
      @(negedge clk); start_i = 0;
      @(negedge clk); start_i = 1; op0_i = 8'hE3; op1_i = 8'hD2;
      @(negedge clk); start_i = 0;
      repeat (3) @(negedge clk);

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule